// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block sits in the memory stage of a 32-bit processor pipeline and examines each load or store request before it reaches the bus. From the request address, the access size and a one-bit instruction class, it works out two things. The first is whether the address meets the natural alignment for that size. The second is whether the instruction is one of the few load/store forms that may legally touch an unaligned address.

When a valid request is misaligned and its form does not allow that, the block raises a usage-fault pulse one clock later. The fault handler and any bus splitting of unaligned transfers live elsewhere. The aligned and permitted flags are combinational views of the request currently on the inputs. The fault output is registered and sampled only on cycles where the valid strobe is high.

Top module: `mem_align_check`

## Requirements
- R1: During and immediately after a synchronous active-low reset, `usage_fault` is 0.
- R2: A byte access (`req_size` = 0) always reports `is_aligned` = 1, whatever the address.
- R3: A halfword access (`req_size` = 1) reports `is_aligned` = 1 exactly when `req_addr[0]` is 0.
- R4: Word (`req_size` = 2), dual-word (3) and multiple-word (4) accesses report `is_aligned` = 1 exactly when `req_addr[1:0]` is 2'b00.
- R5: `unalign_ok` is 1 exactly when `req_unalign_form` is 1 and `req_size` is halfword (1) or word (2); it is 0 for every other size or when the class bit is 0.
- R6: `usage_fault` is 1 in the cycle after a clock edge that samples `req_valid` = 1 with `is_aligned` = 0 and `unalign_ok` = 0, and is 0 in the cycle after any edge where these conditions do not hold.
- R7: A request presented with `req_valid` = 0 never produces `usage_fault`, whatever its address, size or class.
- R8: A misaligned dual-word or multiple-word access faults under both values of `req_unalign_form`.
- R9: Reserved size codes 5, 6 and 7 are treated like a multiple-word access: they need `req_addr[1:0]` = 2'b00 and are never permitted unaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W (32) | Byte address of the access |
| req_size | input | 3 | Access size: 0 byte, 1 halfword, 2 word, 3 dual word, 4 multiple word, 5-7 reserved |
| req_unalign_form | input | 1 | 1 when the instruction is a word/halfword load/store form allowed to be unaligned |
| is_aligned | output | 1 | Address meets natural alignment for the size |
| unalign_ok | output | 1 | Unaligned address allowed for this request |
| usage_fault | output | 1 | One-cycle pulse for a disallowed unaligned valid request |

## Verification
The main sweep covers every size code from 0 to 7 against all four values of the low two address bits under both class values, with varied upper address bits. This separates the halfword rule, which ignores bit 1, from the word rule, which needs both low bits clear. It also separates sizes that the class bit can rescue from sizes that it cannot. Each faulting request is followed by an idle cycle with the same misaligned address left on the bus but `req_valid` low, showing that the fault lasts one cycle and that an invalid request never faults. A final back-to-back pair of faulting requests shows that a fault is raised for each request.

// File: rtl/mac_pkg.sv
// Package: shared encodings for the memory alignment checker.
// Assumes size codes fit in three bits; codes above MAC_MULTI are reserved.
package mac_pkg;
    localparam int SIZE_W = 3;

    typedef enum logic [SIZE_W-1:0] {
        MAC_BYTE  = 3'd0,
        MAC_HALF  = 3'd1,
        MAC_WORD  = 3'd2,
        MAC_DUAL  = 3'd3,
        MAC_MULTI = 3'd4
    } mac_size_e;

    // Number of low address bits that must be zero for a given size code.
    function automatic int unsigned mac_align_bits(input logic [SIZE_W-1:0] sz);
        case (sz)
            MAC_BYTE: return 0;
            MAC_HALF: return 1;
            default:  return 2;
        endcase
    endfunction
endpackage

// File: rtl/mac_align_decode.sv
// Module: mac_align_decode
// Decides whether the low address bits meet natural alignment for the size.
// Assumes LOW_W >= 2 so word alignment can be tested; reserved sizes need word alignment.
module mac_align_decode
    import mac_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0]  addr_low,
    input  logic [SIZE_W-1:0] size,
    output logic              aligned
);
    // One mask bit per low address bit; generate marks which bits a size demands be zero.
    logic [LOW_W-1:0] need_zero;

    for (genvar b = 0; b < LOW_W; b++) begin : g_mask
        // Bit b must be zero when the size needs more than b alignment bits.
        assign need_zero[b] = (mac_align_bits(size) > b);
    end

    // Aligned when no demanded bit is set.
    always_comb begin
        aligned = ~|(addr_low & need_zero);
    end
endmodule

// File: rtl/mac_permit_decode.sv
// Module: mac_permit_decode
// Decides whether this request may legally use an unaligned address.
// Assumes only halfword and word sizes of the marked instruction class qualify.
module mac_permit_decode
    import mac_pkg::*;
(
    input  logic              unalign_form,
    input  logic [SIZE_W-1:0] size,
    output logic              permitted
);
    // Permission: marked class and a halfword or word size.
    always_comb begin
        case (size)
            MAC_HALF, MAC_WORD: permitted = unalign_form;
            default:            permitted = 1'b0;
        endcase
    end
endmodule

// File: rtl/mac_fault_reg.sv
// Module: mac_fault_reg
// Registers the usage-fault decision for one cycle.
// Assumes a synchronous active-low reset; a fault is captured only when valid is high.
module mac_fault_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic aligned,
    input  logic permitted,
    output logic fault
);
    // Capture the fault condition for the request sampled on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else begin
            fault <= valid & ~aligned & ~permitted;
        end
    end
endmodule

// File: rtl/mem_align_check.sv
// Module: mem_align_check
// Top level: checks each load/store request for alignment and raises a registered
// usage-fault pulse for disallowed unaligned accesses.
// Assumes ADDR_W >= 2; only the low two address bits matter to the checks.
module mem_align_check
    import mac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic              req_unalign_form,
    output logic              is_aligned,
    output logic              unalign_ok,
    output logic              usage_fault
);
    localparam int LOW_W = 2;

    logic [LOW_W-1:0] addr_low;

    // Pick out the address bits that alignment depends on.
    always_comb begin
        addr_low = req_addr[LOW_W-1:0];
    end

    mac_align_decode #(.LOW_W(LOW_W)) u_align (
        .addr_low (addr_low),
        .size     (req_size),
        .aligned  (is_aligned)
    );

    mac_permit_decode u_permit (
        .unalign_form (req_unalign_form),
        .size         (req_size),
        .permitted    (unalign_ok)
    );

    mac_fault_reg u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .aligned   (is_aligned),
        .permitted (unalign_ok),
        .fault     (usage_fault)
    );
endmodule

// File: rtl/mem_align_check_sva.sv
// Module: mem_align_check_sva
// Checker bound to mem_align_check; observes ports only.
module mem_align_check_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic              req_unalign_form,
    input logic              is_aligned,
    input logic              unalign_ok,
    input logic              usage_fault
);
    // R1: reset edge clears the fault.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !usage_fault);

    // R2: byte accesses are always aligned.
    assert_byte_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 3'd0) |-> is_aligned);

    // R3: an odd halfword address is misaligned.
    assert_half_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 3'd1 && req_addr[0]) |-> !is_aligned);

    // R5: permission never granted when the class bit is clear.
    assert_no_permit_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_unalign_form |-> !unalign_ok);

    // R6: a valid, misaligned, unpermitted request faults next cycle.
    assert_fault_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_aligned && !unalign_ok) |=> usage_fault);

    // R7: no valid, no fault next cycle.
    assert_idle_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !usage_fault);

    // R8: misaligned dual/multi word always faults.
    assert_dual_multi_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size == 3'd3 || req_size == 3'd4) && req_addr[1:0] != 2'b00)
        |=> usage_fault);

    // R9: reserved sizes are never permitted unaligned.
    assert_reserved_no_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size >= 3'd5) |-> !unalign_ok);
endmodule

bind mem_align_check mem_align_check_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_addr         (req_addr),
    .req_size         (req_size),
    .req_unalign_form (req_unalign_form),
    .is_aligned       (is_aligned),
    .unalign_ok       (unalign_ok),
    .usage_fault      (usage_fault)
);

// File: tb/tb_mem_align_check.sv
// Bench: exhaustive sweep of size, low address bits and class, expected values computed arithmetically.
module tb_mem_align_check;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [2:0]        req_size;
    logic              req_unalign_form;
    logic              is_aligned;
    logic              unalign_ok;
    logic              usage_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mem_align_check #(.ADDR_W(ADDR_W)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_addr         (req_addr),
        .req_size         (req_size),
        .req_unalign_form (req_unalign_form),
        .is_aligned       (is_aligned),
        .unalign_ok       (unalign_ok),
        .usage_fault      (usage_fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (size %0d addr %h class %b)",
                     req, act, exp, req_size, req_addr, req_unalign_form);
        end
    endtask

    // Expected alignment from the rules: byte any, half bit0 clear, others bits1:0 clear.
    function automatic logic exp_aligned(input int sz, input int low);
        if (sz == 0) return 1'b1;
        if (sz == 1) return (low % 2) == 0;
        return low == 0;
    endfunction

    function automatic logic exp_permit(input int sz, input int cls);
        return (cls == 1) && (sz == 1 || sz == 2);
    endfunction

    function automatic string align_req(input int sz);
        if (sz == 0) return "R2";
        if (sz == 1) return "R3";
        if (sz <= 4) return "R4";
        return "R9";
    endfunction

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_addr = 32'h0000_0003;
        req_size = 3'd3; req_unalign_form = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", usage_fault, 1'b0);
        rst_n = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        check("R1", usage_fault, 1'b0);

        for (int sz = 0; sz < 8; sz++) begin
            for (int cls = 0; cls < 2; cls++) begin
                for (int low = 0; low < 4; low++) begin
                    logic ea, ep, ef;
                    ea = exp_aligned(sz, low);
                    ep = exp_permit(sz, cls);
                    ef = !ea && !ep;
                    req_valid = 1'b1;
                    req_size = sz[2:0];
                    req_unalign_form = cls[0];
                    req_addr = {28'h9A5_C3E1 ^ {25'd0, sz[2:0]} , 2'b00, low[1:0]};
                    #1;
                    check(align_req(sz), is_aligned, ea);
                    check(sz >= 5 ? "R9" : "R5", unalign_ok, ep);
                    @(negedge clk);
                    check((sz == 3 || sz == 4) ? "R8" : "R6", usage_fault, ef);
                    req_valid = 1'b0;   // same misaligned request, strobe low
                    @(negedge clk);
                    check("R7", usage_fault, 1'b0);
                end
            end
        end

        // Back-to-back faulting requests each fault.
        req_valid = 1'b1; req_size = 3'd2; req_unalign_form = 1'b0; req_addr = 32'h1000_0002;
        @(negedge clk);
        check("R6", usage_fault, 1'b1);
        req_size = 3'd4; req_unalign_form = 1'b1; req_addr = 32'h1000_0001;
        @(negedge clk);
        check("R8", usage_fault, 1'b1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R6", usage_fault, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule